// File: doc/BRIEF.md
# SIMD Warp Issue Sequencer

This block decides which group of threads (a warp) sends its next instruction to a narrow array of SIMD lanes, and which threads the lanes serve in each cycle. A warp holds more threads than there are lanes, so each warp instruction is spread over several back-to-back cycles. In each of those cycles one slice of threads, as wide as the lane array, is presented to the lanes.

Many warp contexts stay resident at the same time. Each warp raises its bit in a ready vector when it can issue. When an issue finishes, the sequencer moves to another ready warp. It chooses in round-robin order, so that warps waiting on memory are covered by the work of the others. With the default parameters there are 24 warps of 32 threads each, running on 8 lanes over 4 cycles per instruction.

Top module: `wis_sequencer`

## Requirements
- R1: During reset and in the cycle after it, `issue_valid` is 0. After reset the round-robin search starts at warp 0.
- R2: If no issue is in progress and at least one `warp_ready` bit is set on a clock edge, then after that edge `issue_valid` is 1 and `issue_group` is 0.
- R3: An issue lasts exactly GROUPS = THREADS/LANES consecutive valid cycles, with `issue_group` taking the values 0, 1, ..., GROUPS-1 in order (0 to 3 by default).
- R4: `issue_warp` does not change during an issue, whatever `warp_ready` does in its middle cycles.
- R5: At a selection point, the chosen warp is the first index with its `warp_ready` bit set, searching upward from (last issued warp + 1).
- R6: While `issue_valid` is 1, lane j's field `lane_thread[j*TW +: TW]` equals `issue_group*LANES + j`, where TW = clog2(THREADS).
- R7: If `warp_ready` is all zero at a selection point, `issue_valid` is 0 after the edge. It stays 0 until an edge at which some bit is set.
- R8: When a warp is ready at the last cycle of an issue, the next issue starts in the very next cycle, with no idle cycle between them. The warp just issued is picked again only when it is the only ready warp.
- R9: The search wraps from the highest warp index (WARPS-1) back to warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | WARPS | One bit per resident warp, set when that warp can issue |
| issue_valid | output | 1 | The lanes hold a valid slice of a warp instruction |
| issue_warp | output | clog2(WARPS) | Index of the warp being issued |
| issue_group | output | clog2(THREADS/LANES) | Which thread slice of the warp is in the lanes |
| lane_thread | output | LANES*clog2(THREADS) | Thread index served by each lane, lane 0 in the low bits |

## Verification
A wrong slice counter shows up at once as a group sequence that skips or repeats a value, or as an issue that is longer or shorter than GROUPS cycles. Because `lane_thread` follows the group, the lane indices go wrong in the same cycle. A wrong round-robin pointer stays hidden until the next selection point. At most GROUPS cycles later it shows as the wrong `issue_warp`, so the tests load several ready bits and walk through the wrap at the top index. A selection state that leaks through shows as an issue cut short when `warp_ready` changes mid-instruction, or as a valid cycle after a selection point with nothing ready.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int DEF_WARPS   = 24;
    localparam int DEF_THREADS = 32;
    localparam int DEF_LANES   = 8;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } issue_phase_e;

    // width helper that never returns zero
    function automatic int safe_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // (base + off) modulo n, for base < n and off < n
    function automatic int wrap_idx(input int base, input int off, input int n);
        int s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/wis_rr_picker.sv
module wis_rr_picker
    import wis_pkg::*;
#(
    parameter int WARPS = DEF_WARPS,
    parameter int IW    = safe_w(DEF_WARPS)
) (
    input  logic [WARPS-1:0] ready,
    input  logic [IW-1:0]    last,
    output logic             found,
    output logic [IW-1:0]    pick
);

    int start_idx;

    always_comb begin
        start_idx = wrap_idx(int'(last), 1, WARPS);
        found = 1'b0;
        pick  = '0;
        // scan from the farthest offset down so the nearest ready warp wins
        for (int off = WARPS - 1; off >= 0; off--) begin
            if (ready[wrap_idx(start_idx, off, WARPS)]) begin
                found = 1'b1;
                pick  = IW'(wrap_idx(start_idx, off, WARPS));
            end
        end
    end

endmodule

// File: rtl/wis_issue_fsm.sv
module wis_issue_fsm
    import wis_pkg::*;
#(
    parameter int WARPS  = DEF_WARPS,
    parameter int GROUPS = DEF_THREADS / DEF_LANES,
    parameter int IW     = safe_w(DEF_WARPS),
    parameter int GW     = safe_w(DEF_THREADS / DEF_LANES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pick_found,
    input  logic [IW-1:0] pick_idx,
    output logic          valid,
    output logic [IW-1:0] cur_warp,
    output logic [GW-1:0] group
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    issue_phase_e phase_q;
    logic [IW-1:0] warp_q;
    logic [GW-1:0] grp_q;
    logic          sel_point;

    assign sel_point = (phase_q == PH_IDLE) || (grp_q == LAST_GRP);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            grp_q   <= '0;
            warp_q  <= IW'(WARPS - 1);
        end else if (sel_point) begin
            grp_q <= '0;
            if (pick_found) begin
                phase_q <= PH_ISSUE;
                warp_q  <= pick_idx;
            end else begin
                phase_q <= PH_IDLE;
            end
        end else begin
            grp_q <= grp_q + 1'b1;
        end
    end

    assign valid    = (phase_q == PH_ISSUE);
    assign cur_warp = warp_q;
    assign group    = grp_q;

endmodule

// File: rtl/wis_lane_map.sv
module wis_lane_map
    import wis_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int GW    = safe_w(DEF_THREADS / DEF_LANES),
    parameter int TW    = safe_w(DEF_THREADS)
) (
    input  logic [GW-1:0]       group,
    output logic [LANES*TW-1:0] lane_thread
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_thread[j*TW +: TW] = TW'(int'(group) * LANES + j);
    end

endmodule

// File: rtl/wis_sequencer.sv
module wis_sequencer
    import wis_pkg::*;
#(
    parameter int WARPS   = DEF_WARPS,
    parameter int THREADS = DEF_THREADS,
    parameter int LANES   = DEF_LANES,
    localparam int GROUPS = THREADS / LANES,
    localparam int IW     = safe_w(WARPS),
    localparam int GW     = safe_w(GROUPS),
    localparam int TW     = safe_w(THREADS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WARPS-1:0]    warp_ready,
    output logic                issue_valid,
    output logic [IW-1:0]       issue_warp,
    output logic [GW-1:0]       issue_group,
    output logic [LANES*TW-1:0] lane_thread
);

    logic          pk_found;
    logic [IW-1:0] pk_idx;

    wis_rr_picker #(.WARPS(WARPS), .IW(IW)) u_pick (
        .ready (warp_ready),
        .last  (issue_warp),
        .found (pk_found),
        .pick  (pk_idx)
    );

    wis_issue_fsm #(.WARPS(WARPS), .GROUPS(GROUPS), .IW(IW), .GW(GW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pick_found (pk_found),
        .pick_idx   (pk_idx),
        .valid      (issue_valid),
        .cur_warp   (issue_warp),
        .group      (issue_group)
    );

    wis_lane_map #(.LANES(LANES), .GW(GW), .TW(TW)) u_lanes (
        .group       (issue_group),
        .lane_thread (lane_thread)
    );

endmodule

// File: rtl/wis_sequencer_chk.sv
module wis_sequencer_chk #(
    parameter int WARPS  = 24,
    parameter int LANES  = 8,
    parameter int GROUPS = 4,
    parameter int IW     = 5,
    parameter int GW     = 2,
    parameter int TW     = 5
) (
    input logic                clk,
    input logic                rst,
    input logic [WARPS-1:0]    warp_ready,
    input logic                issue_valid,
    input logic [IW-1:0]       issue_warp,
    input logic [GW-1:0]       issue_group,
    input logic [LANES*TW-1:0] lane_thread
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    // R3
    grp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_group != LAST_GRP) |=>
            (issue_valid && issue_group == $past(issue_group) + 1'b1));

    // R4
    warp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_group != LAST_GRP) |=> (issue_warp == $past(issue_warp)));

    // R2
    start_group_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!issue_valid || issue_group == '0));

    // R5
    pick_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_group == '0) |-> ((($past(warp_ready) >> issue_warp) & 1) != 0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((!issue_valid || issue_group == LAST_GRP) && warp_ready == '0) |=> !issue_valid);

    // R6
    always @(posedge clk) begin
        if (!rst && issue_valid) begin
            for (int j = 0; j < LANES; j++) begin
                lane_map_chk: assert (lane_thread[j*TW +: TW] == TW'(int'(issue_group) * LANES + j));
            end
        end
    end

endmodule

bind wis_sequencer wis_sequencer_chk #(
    .WARPS(WARPS), .LANES(LANES), .GROUPS(GROUPS), .IW(IW), .GW(GW), .TW(TW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .warp_ready  (warp_ready),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_group (issue_group),
    .lane_thread (lane_thread)
);

// File: tb/wis_sequencer_test.sv
module wis_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WARPS  = 24;
    localparam int LANES  = 8;
    localparam int GROUPS = 4;
    localparam int IW = 5;
    localparam int GW = 2;
    localparam int TW = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [WARPS-1:0]    warp_ready = '0;
    logic                issue_valid;
    logic [IW-1:0]       issue_warp;
    logic [GW-1:0]       issue_group;
    logic [LANES*TW-1:0] lane_thread;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wis_sequencer uut (
        .clk(clk), .rst(rst), .warp_ready(warp_ready),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_group(issue_group), .lane_thread(lane_thread)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WARPS-1:0] bit_of(input int w);
        return WARPS'(1) << w;
    endfunction

    // Watches one full issue of warp w. mid is driven during the middle cycles,
    // nxt at the last cycle (the next selection point).
    task automatic expect_issue(input int w, input logic [WARPS-1:0] mid,
                                input logic [WARPS-1:0] nxt, input string req);
        for (int g = 0; g < GROUPS; g++) begin
            @(negedge clk);
            chk(issue_valid == 1'b1, {req, " R3 valid"}, int'(issue_valid), 1);
            chk(int'(issue_warp) == w, {req, " R4 warp"}, int'(issue_warp), w);
            chk(int'(issue_group) == g, {req, " R3 group"}, int'(issue_group), g);
            for (int j = 0; j < LANES; j++)
                chk(int'(lane_thread[j*TW +: TW]) == g * LANES + j, "R6 lane thread",
                    int'(lane_thread[j*TW +: TW]), g * LANES + j);
            warp_ready = (g == GROUPS - 1) ? nxt : mid;
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(issue_valid == 1'b0, req, int'(issue_valid), 0);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        warp_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1 valid in reset", int'(issue_valid), 0);
        rst = 1'b0;
        expect_idle(1, "R1 valid after reset");
    endtask

    task automatic t_idle_single;
        expect_idle(3, "R7 nothing ready");
        warp_ready = bit_of(5);
        expect_issue(5, '0, '0, "R2 single warp");
        expect_idle(3, "R7 ready dropped");
    endtask

    task automatic t_round_robin;
        logic [WARPS-1:0] set3;
        set3 = bit_of(2) | bit_of(9) | bit_of(20);
        warp_ready = set3;
        expect_issue(9, '1, set3, "R5 after 5");
        expect_issue(20, bit_of(9), set3, "R5 after 9 R8");
        expect_issue(2, '0, bit_of(23), "R9 wrap to 2");
        expect_issue(23, '1, bit_of(0) | bit_of(23), "R5 up to 23");
        expect_issue(0, '0, bit_of(0), "R9 wrap 23 to 0");
        expect_issue(0, '1, '0, "R8 sole warp reissued");
        expect_idle(2, "R7 idle after run");
    endtask

    task automatic t_reset_mid;
        warp_ready = bit_of(7);
        @(negedge clk);
        chk(issue_valid && int'(issue_warp) == 7, "R2 start 7", int'(issue_warp), 7);
        rst = 1'b1;
        warp_ready = bit_of(3) | bit_of(0);
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1 reset cuts issue", int'(issue_valid), 0);
        rst = 1'b0;
        expect_issue(0, '0, '0, "R1 pointer back to 0");
        expect_idle(1, "R7 idle end");
    endtask

    initial begin
        t_reset();
        t_idle_single();
        t_round_robin();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule